// File: doc/BRIEF.md
# I2C SCL Period Generator

This block times the clock line of an I2C master. The module clock is first divided by a fixed number of clocks per count. The low phase and the high phase of SCL each then last a programmed number of these prescaled ticks. The low phase starts counting on the cycle the block starts pulling SCL low, so its count must cover the minimum low time plus the line fall time. The high phase does not start counting when SCL is released. It starts only once the sensed SCL line has passed a synchronizer and reads high. A slow rise time or a slave that holds the clock low therefore lengthens the released phase and does not shorten the high time.

Each count is nine bits wide. The lower eight bits come from the low-count and high-count bytes. Bit 8 of each count arrives on its own input: bit 7 of the neighbour's interrupt-control byte gives the ninth bit of the low count, and bit 6 gives the ninth bit of the high count. With the `NINTH_EN` parameter cleared, the ninth bits are ignored and counts are limited to 0xFF. Typical settings are 4.7 µs low and 4.0 µs high for standard mode, or 1.3 µs low and 0.6 µs high for fast mode, each with 0.3 µs added for the fall time.

The byte engine drives a hold request to stretch the low phase while it is busy. It receives a single-cycle pulse on every SCL edge the block produces or observes. Each count is captured when its phase begins.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is applied or `enable` is low, `scl_drive_low` is 0 and neither tick pulses. Within one clock of `enable` falling, SCL is released.
- R2: With prescale ratio P, a low phase keeps `scl_drive_low` at 1 for exactly Lc·P clocks. Lc is `{low_msb, low_count}` and is captured when the phase starts.
- R3: Once SCL is released, high counting begins on the clock after the synchronized line (SYNC_STAGES flops) reads high. `rise_tick` marks the first counting clock. `fall_tick` follows exactly Hc·P clocks later, where Hc is `{high_msb, high_count}`. With an undelayed line, the released phase lasts SYNC_STAGES+1+Hc·P clocks.
- R4: If the sensed line stays low for X extra clocks after release (clock stretching), the released phase grows by exactly X clocks while the rise-to-fall distance stays Hc·P.
- R5: `low_msb` and `high_msb` supply bit 8 of the low count and the high count, so counts up to 0x1FF are reachable.
- R6: A count that evaluates to 0 behaves as a count of 1, giving one prescaled tick.
- R7: When the low count has expired while `hold_req` is 1, SCL stays driven low. SCL is released on the clock edge after `hold_req` is first sampled 0.
- R8: `fall_tick` is a one-clock pulse in the first clock of every low phase. `rise_tick` is a one-clock pulse only while SCL is released and sensed high. The two never coincide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the SCL generator; low releases SCL and parks the block |
| low_count | input | 8 | Low-phase count, bits 7..0 |
| low_msb | input | 1 | Low-phase count bit 8 (control byte bit 7) |
| high_count | input | 8 | High-phase count, bits 7..0 |
| high_msb | input | 1 | High-phase count bit 8 (control byte bit 6) |
| hold_req | input | 1 | Byte engine request to keep SCL low after the low count |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | Open-drain drive: 1 pulls SCL low, 0 releases it |
| fall_tick | output | 1 | One-clock pulse when SCL is pulled low |
| rise_tick | output | 1 | One-clock pulse when the released SCL is seen high |

## Verification
The embedded assertions watch several properties on every clock:
- SCL is released after `enable` drops.
- A held low phase never releases SCL.
- The two ticks are exclusive, and each sits on its own edge.
- The phase counter never runs past its target.

Exact phase lengths can only be shown by the bench's scenarios. These include the prescaled low and high durations, the synchronizer delay in the released phase, and the extra clocks added by a stretching slave. The same holds for the effect of the ninth bits, the zero-count floor, and the clock on which a hold ends. A scoreboard compares each measured SCL run against lengths computed from the programmed counts.

// File: rtl/scl_gen_pkg.sv
// Shared definitions for the SCL period generator.
package scl_gen_pkg;

    // Phases of the SCL waveform as seen by the controller
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // disabled, line released
        PH_LOW  = 2'd1,   // line pulled low, low count running
        PH_WAIT = 2'd2,   // line released, waiting to sense it high
        PH_HIGH = 2'd3    // line high, high count running
    } scl_phase_e;

endpackage

// File: rtl/scl_count_sel.sv
// Builds the effective nine-bit phase counts from the low byte and the
// extension bit of each count. Assumes the caller holds the inputs stable
// around phase entry; a zero result is raised to one tick.
module scl_count_sel #(
    parameter int BYTE_W   = 8,
    parameter bit NINTH_EN = 1'b1,
    localparam int CW      = BYTE_W + 1
) (
    input  logic [BYTE_W-1:0] low_byte,
    input  logic              low_ext,
    input  logic [BYTE_W-1:0] high_byte,
    input  logic              high_ext,
    output logic [CW-1:0]     low_eff,
    output logic [CW-1:0]     high_eff
);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [CW-1:0] low_raw;
    logic [CW-1:0] high_raw;

    generate
        if (NINTH_EN) begin : g_ext
            // Extension bits become bit 8 of each count
            assign low_raw  = {low_ext,  low_byte};
            assign high_raw = {high_ext, high_byte};
        end else begin : g_no_ext
            // Without extension bits the counts stop at the byte maximum
            logic unused_ext;
            assign unused_ext = low_ext ^ high_ext;
            assign low_raw    = {1'b0, low_byte};
            assign high_raw   = {1'b0, high_byte};
        end
    endgenerate

    // Floor each count at one tick
    always_comb begin
        low_eff  = (low_raw  == '0) ? CNT_ONE : low_raw;
        high_eff = (high_raw == '0) ? CNT_ONE : high_raw;
    end
endmodule

// File: rtl/scl_line_sync.sv
// Synchronizes the sensed SCL level into the module clock domain with a
// parameterized flop chain. Assumes STAGES >= 1; reset value is low.
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw line level through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= (chain << 1) | STAGES'(line_in);
        end
    end

    assign line_sync = chain[STAGES-1];
endmodule

// File: rtl/scl_prescaler.sv
// Divides the module clock into count ticks. The divider restarts at each
// phase entry so every phase length is an exact multiple of DIV clocks.
// Assumes DIV >= 1; ticks only while run is high.
module scl_prescaler #(
    parameter int DIV = 4,
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV == 1) begin : g_pass
            // Every clock is a tick
            logic unused_pins;
            assign unused_pins = restart ^ rst_n ^ clk;
            assign tick = run;
        end else begin : g_div
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pre_cnt;

            // Count module clocks within one tick, reset on phase entry
            always_ff @(posedge clk) begin
                if (!rst_n || restart || !run) begin
                    pre_cnt <= '0;
                end else if (pre_cnt == LAST) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + PW'(1);
                end
            end

            assign tick = run && (pre_cnt == LAST);

            AST_NO_TICK_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick);  // R2
        end
    endgenerate
endmodule

// File: rtl/scl_phase_ctrl.sv
// Phase sequencer for SCL: pulls the line low for the low count, releases
// it, waits for the synchronized line to read high, then times the high
// count. Assumes low_eff/high_eff are never zero and tick comes from a
// prescaler restarted by this module's restart output.
module scl_phase_ctrl
    import scl_gen_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          hold_req,
    input  logic          line_hi,
    input  logic          tick,
    input  logic [CW-1:0] low_eff,
    input  logic [CW-1:0] high_eff,
    output logic          run,
    output logic          restart,
    output logic          drive_low,
    output logic          fall_tick,
    output logic          rise_tick
);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    scl_phase_e    st, st_nx;
    logic [CW-1:0] tgt;
    logic [CW-1:0] ph_cnt;
    logic          last;
    logic          fall_ev;
    logic          rise_ev;

    // The phase ends on the tick that reaches the target, or later if held
    assign last = (ph_cnt == tgt) || (tick && (ph_cnt == tgt - CNT_ONE));

    // Next-phase decision and edge events
    always_comb begin
        st_nx   = st;
        fall_ev = 1'b0;
        rise_ev = 1'b0;
        if (!enable) begin
            st_nx = PH_IDLE;
        end else begin
            case (st)
                PH_IDLE: begin
                    st_nx   = PH_LOW;
                    fall_ev = 1'b1;
                end
                PH_LOW: begin
                    if (last && !hold_req) st_nx = PH_WAIT;
                end
                PH_WAIT: begin
                    if (line_hi) begin
                        st_nx   = PH_HIGH;
                        rise_ev = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (last) begin
                        st_nx   = PH_LOW;
                        fall_ev = 1'b1;
                    end
                end
                default: st_nx = PH_IDLE;
            endcase
        end
    end

    assign restart = ((st_nx == PH_LOW)  && (st != PH_LOW)) ||
                     ((st_nx == PH_HIGH) && (st != PH_HIGH));

    // Phase register and registered edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= PH_IDLE;
            fall_tick <= 1'b0;
            rise_tick <= 1'b0;
        end else begin
            st        <= st_nx;
            fall_tick <= fall_ev;
            rise_tick <= rise_ev;
        end
    end

    // Capture the target at phase entry and count ticks up to it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt    <= CNT_ONE;
            ph_cnt <= '0;
        end else if (restart) begin
            tgt    <= (st_nx == PH_LOW) ? low_eff : high_eff;
            ph_cnt <= '0;
        end else if (tick && (ph_cnt != tgt)) begin
            ph_cnt <= ph_cnt + CNT_ONE;
        end
    end

    assign run       = (st == PH_LOW) || (st == PH_HIGH);
    assign drive_low = (st == PH_LOW);

    AST_RELEASE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !drive_low);  // R1
    AST_HOLD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low && hold_req && enable) |=> drive_low);  // R7
    AST_TICKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_tick && rise_tick));  // R8
    AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |-> (drive_low && !$past(drive_low)));  // R8
    AST_RISE_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |-> (!drive_low && $past(line_hi)));  // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ph_cnt <= tgt);  // R2
endmodule

// File: rtl/scl_phase_gen.sv
// Top of the SCL period generator: count composition, line synchronizer,
// prescaler and phase sequencer. Assumes scl_in reflects the wired-AND
// SCL line and that scl_drive_low controls an open-drain pad.
module scl_phase_gen
    import scl_gen_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter bit NINTH_EN      = 1'b1,
    parameter int CLK_PER_COUNT = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [BYTE_W-1:0] low_count,
    input  logic              low_msb,
    input  logic [BYTE_W-1:0] high_count,
    input  logic              high_msb,
    input  logic              hold_req,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              fall_tick,
    output logic              rise_tick
);
    localparam int CW = BYTE_W + 1;

    logic [CW-1:0] low_eff;
    logic [CW-1:0] high_eff;
    logic          line_hi;
    logic          tick;
    logic          run;
    logic          restart;

    scl_count_sel #(
        .BYTE_W   (BYTE_W),
        .NINTH_EN (NINTH_EN)
    ) i_count_sel (
        .low_byte  (low_count),
        .low_ext   (low_msb),
        .high_byte (high_count),
        .high_ext  (high_msb),
        .low_eff   (low_eff),
        .high_eff  (high_eff)
    );

    scl_line_sync #(
        .STAGES (SYNC_STAGES)
    ) i_line_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (scl_in),
        .line_sync (line_hi)
    );

    scl_prescaler #(
        .DIV (CLK_PER_COUNT)
    ) i_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (tick)
    );

    scl_phase_ctrl #(
        .CW (CW)
    ) i_phase_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .hold_req  (hold_req),
        .line_hi   (line_hi),
        .tick      (tick),
        .low_eff   (low_eff),
        .high_eff  (high_eff),
        .run       (run),
        .restart   (restart),
        .drive_low (scl_drive_low),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick)
    );
endmodule

// File: tb/test_scl_phase_gen.sv
// Scoreboard bench: each scenario pushes the expected SCL run lengths,
// a negedge monitor measures runs and compares them in order.
module test_scl_phase_gen;
    localparam int P    = 4;
    localparam int SYNC = 2;
    localparam int K_LOW = 0, K_REL = 1, K_HI = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       hold_req = 1'b0;
    logic       low_msb = 1'b0;
    logic       high_msb = 1'b0;
    logic       stretch = 1'b0;
    logic [7:0] low_count = 8'd0;
    logic [7:0] high_count = 8'd0;
    logic       scl_in;
    logic       scl_drive_low;
    logic       fall_tick;
    logic       rise_tick;

    // Pull-up line model with an optional stretching slave
    assign scl_in = !scl_drive_low && !stretch;

    scl_phase_gen #(
        .BYTE_W        (8),
        .NINTH_EN      (1'b1),
        .CLK_PER_COUNT (P),
        .SYNC_STAGES   (SYNC)
    ) i_scl_phase_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .low_count     (low_count),
        .low_msb       (low_msb),
        .high_count    (high_count),
        .high_msb      (high_msb),
        .hold_req      (hold_req),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .fall_tick     (fall_tick),
        .rise_tick     (rise_tick)
    );

    typedef struct {
        int    kind;
        int    len;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    stretch_cycles = 0;
    logic  mon_en = 1'b0;
    bit    done = 1'b0;

    function automatic void check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endfunction

    function automatic void push(int kind, int len, string tag);
        item_t it;
        it.kind = kind;
        it.len  = len;
        it.tag  = tag;
        exp_q.push_back(it);
    endfunction

    function automatic void finalize(int kind, int len);
        item_t it;
        if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected SCL run kind", kind, -1);
        end else begin
            it = exp_q.pop_front();
            check(it.kind == kind, it.tag, "run kind", kind, it.kind);
            check(it.len == len, it.tag, "run length", len, it.len);
        end
    endfunction

    // Effective count from the requirements: 9-bit value, zero floored to one
    function automatic int eff(int lo, int msb);
        int v = (msb << 8) | lo;
        return (v == 0) ? 1 : v;
    endfunction

    // Monitor: measures line runs and rise-to-fall distance at negedges
    logic prev_drive = 1'b0;
    int   run_len = 0;
    bit   started = 1'b0;
    bit   hi_on = 1'b0;
    int   hi_len = 0;
    always @(negedge clk) begin
        if (!mon_en) begin
            prev_drive = scl_drive_low;
            started    = 1'b0;
            hi_on      = 1'b0;
            run_len    = 0;
        end else begin
            if (rise_tick)
                check(!scl_drive_low && scl_in, "R8", "rise_tick with line high", int'(scl_in), 1);
            if (scl_drive_low != prev_drive) begin
                check(fall_tick == scl_drive_low, "R8", "fall_tick at pull-low edge",
                      int'(fall_tick), int'(scl_drive_low));
                if (started) finalize(prev_drive ? K_LOW : K_REL, run_len);
                started = 1'b1;
                run_len = 1;
            end else begin
                if (fall_tick)
                    check(1'b0, "R8", "fall_tick without edge", 1, 0);
                run_len++;
            end
            if (hi_on && !rise_tick) hi_len++;
            if (fall_tick && hi_on) begin
                finalize(K_HI, hi_len);
                hi_on = 1'b0;
            end
            if (rise_tick) begin
                hi_on  = 1'b1;
                hi_len = 0;
            end
            prev_drive = scl_drive_low;
        end
    end

    // Stretching slave: keeps the line low for stretch_cycles after release
    initial begin
        logic last_drive = 1'b0;
        forever begin
            @(negedge clk);
            if (last_drive && !scl_drive_low && stretch_cycles > 0) begin
                #1 stretch = 1'b1;
                repeat (stretch_cycles) @(negedge clk);
                #1 stretch = 1'b0;
            end
            last_drive = scl_drive_low;
        end
    end

    // One scenario: program, push expectations, run, disable
    task automatic run_case(int lo, int lm, int hi, int hm, int nper,
                            int str, int hold_t, string low_tag);
        int L = eff(lo, lm);
        int H = eff(hi, hm);
        @(negedge clk);
        #1;
        low_count      = 8'(lo);
        low_msb        = lm[0];
        high_count     = 8'(hi);
        high_msb       = hm[0];
        stretch_cycles = str;
        hold_req       = (hold_t > 0);
        push(K_LOW, (hold_t > 0) ? hold_t : L * P, (hold_t > 0) ? "R7" : low_tag);
        for (int k = 0; k < nper; k++) begin
            push(K_REL, str + SYNC + 1 + H * P, (str > 0) ? "R4" : "R3");
            push(K_HI, H * P, (hm != 0) ? "R5" : "R3");
            push(K_LOW, L * P, low_tag);
        end
        enable = 1'b1;
        mon_en = 1'b1;
        if (hold_t > 0) begin
            int c = 0;
            while (c < hold_t) begin
                @(negedge clk);
                if (scl_drive_low) c++;
            end
            #1 hold_req = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        #1;
        enable = 1'b0;
        mon_en = 1'b0;
        repeat (2) @(negedge clk);
        check(!scl_drive_low && !fall_tick && !rise_tick, "R1",
              "line released after disable", int'(scl_drive_low), 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(!scl_drive_low && !fall_tick && !rise_tick, "R1", "reset state", int'(scl_drive_low), 0);
        #1 rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(!scl_drive_low && !fall_tick && !rise_tick, "R1", "disabled state", int'(scl_drive_low), 0);

        run_case(5, 0, 4, 0, 3, 0, 0, "R2");     // R2 R3 basic periods
        run_case(10, 0, 7, 0, 2, 0, 0, "R2");    // R2 second pattern
        run_case(0, 0, 0, 0, 2, 0, 0, "R6");     // R6 zero counts
        run_case(2, 1, 1, 1, 1, 0, 0, "R5");     // R5 ninth bits: 258 and 257
        run_case(3, 0, 3, 0, 2, 5, 0, "R2");     // R4 stretch by 5 clocks
        run_case(3, 0, 2, 0, 1, 0, 30, "R2");    // R7 hold for 30 clocks

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule